// File: doc/BRIEF.md
# Full Search Best Match Finder

This block finds, for one 16x16 macroblock of a 96x96 frame, the 16x16 block of the next frame that matches it best. The search window is the macroblock grown by 16 pixels on every side and clipped to the frame. A macroblock in a corner or on an edge therefore gets a smaller window than one in the interior. The block walks every candidate top-left position inside that window. For each candidate it asks an external SAD unit for the sum of absolute differences, then keeps the candidate with the smallest result.

A parent controller picks the macroblock by column and row index and pulses `start`. The block then hands candidates to the SAD unit one at a time through a request/done pulse pair. When the last result is in, it raises `done_req` towards the parent and holds its outputs until the parent acknowledges. The outputs are block-centre coordinates rather than displacement vectors. The start point is the macroblock centre and the end point is the centre of the best candidate, each taken as offset (8,8) from the block's top-left corner.

The controller has four states:
- `ST_RESET` is idle. On `start` it goes to `ST_CALC`.
- `ST_CALC` searches. After the last candidate's result it goes to `ST_DONE`.
- `ST_DONE` reports the result. On `done_ack` it goes to `ST_COMPLETE`.
- `ST_COMPLETE` always goes back to `ST_RESET` one cycle later.

Top module: `fsbm_search`

## Requirements
- R1: After reset, `sad_req` and `done_req` are both 0.
- R2: With origin `ox = mb_col*16`, every candidate x lies in [max(0, ox-16), min(95, ox+31)-15]. The same rule applies to y using `mb_row`. Valid index codes are 0 to 5.
- R3: Candidates are issued in raster order. The sequence starts at the low corner of the window, x advances first and y advances when x wraps. Every position in the window is issued exactly once.
- R4: Each candidate gets exactly one single-cycle `sad_req` pulse. No new pulse comes before `sad_done` returns for the current one. `cand_x`/`cand_y` stay stable while the result is outstanding.
- R5: The kept candidate has the smallest SAD. The comparison is strict less-than, so on equal SAD the earlier candidate in raster order wins.
- R6: The running minimum starts at the all-ones value 0xFFFF, and the best position starts at the first candidate. If every SAD is 0xFFFF, the end point is the first candidate's centre.
- R7: `start_x = mb_col*16 + 8` and `start_y = mb_row*16 + 8`.
- R8: `end_x`/`end_y` equal the best candidate's top-left coordinates plus 8.
- R9: `done_req` rises the cycle after the last `sad_done`. It stays high until `done_ack` and falls the cycle after `done_ack`. The block is idle again one cycle later.
- R10: `start` is ignored outside the idle state, and `sad_done` is ignored when no request is outstanding. Neither changes the candidate sequence or the reported end point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Parent pulse to begin a macroblock (idle only) |
| mb_col | input | 3 | Macroblock column index, 0..5 |
| mb_row | input | 3 | Macroblock row index, 0..5 |
| sad_req | output | 1 | One-cycle request to the SAD unit |
| cand_x | output | 7 | Candidate top-left x |
| cand_y | output | 7 | Candidate top-left y |
| sad_done | input | 1 | SAD unit result pulse |
| sad_value | input | 16 | SAD of the outstanding candidate |
| done_req | output | 1 | Request to the parent: search finished |
| done_ack | input | 1 | Parent acknowledge of `done_req` |
| start_x | output | 7 | Macroblock centre x |
| start_y | output | 7 | Macroblock centre y |
| end_x | output | 7 | Best block centre x |
| end_y | output | 7 | Best block centre y |

## Verification
The assertions assume that `done_ack` is only given while `done_req` is high. They also assume the SAD unit answers each request with a single `sad_done` pulse. The bench's SAD model follows both rules: it waits a fixed latency after each request and pulses done once. It acknowledges only after it has seen `done_req`. Stray pulses are applied on purpose only in the situations R10 describes, namely `start` during a search and `sad_done` while the result is being held.

// File: rtl/fsbm_pkg.sv
package fsbm_pkg;

    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_CALC     = 2'd1,
        ST_DONE     = 2'd2,
        ST_COMPLETE = 2'd3
    } fsbm_state_t;

endpackage

// File: rtl/fsbm_window.sv
// Clipped search-window bounds for one macroblock, per axis (0 = x, 1 = y).
module fsbm_window #(
    parameter int FRAME = 96,
    parameter int BLK   = 16,
    parameter int RANGE = 16,
    parameter int IW    = 3,
    parameter int CW    = 7
) (
    input  logic [1:0][IW-1:0] idx,
    output logic [1:0][CW-1:0] org,
    output logic [1:0][CW-1:0] lo,
    output logic [1:0][CW-1:0] top
);
    localparam int WW = CW + 2;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [WW-1:0] org_w;
        logic [WW-1:0] lo_w;
        logic [WW-1:0] hi_w;

        always_comb begin
            org_w = WW'(idx[a]) * WW'(BLK);
            lo_w  = (org_w >= WW'(RANGE)) ? (org_w - WW'(RANGE)) : '0;
            hi_w  = org_w + WW'(BLK - 1 + RANGE);
            if (hi_w > WW'(FRAME - 1)) begin
                hi_w = WW'(FRAME - 1);
            end
        end

        assign org[a] = CW'(org_w);
        assign lo[a]  = CW'(lo_w);
        assign top[a] = CW'(hi_w - WW'(BLK - 1));
    end
endmodule

// File: rtl/fsbm_scan.sv
// Raster-order candidate position counter.
module fsbm_scan #(
    parameter int CW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [1:0][CW-1:0] lo,
    input  logic [1:0][CW-1:0] top,
    output logic [1:0][CW-1:0] pos,
    output logic              last
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load) begin
            pos <= lo;
        end else if (step) begin
            if (pos[0] == top[0]) begin
                pos[0] <= lo[0];
                pos[1] <= pos[1] + CW'(1);
            end else begin
                pos[0] <= pos[0] + CW'(1);
            end
        end
    end

    assign last = (pos[0] == top[0]) && (pos[1] == top[1]);
endmodule

// File: rtl/fsbm_min_track.sv
// Running minimum of SAD results with the position that produced it.
module fsbm_min_track #(
    parameter int CW   = 7,
    parameter int SADW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic [1:0][CW-1:0] init_pos,
    input  logic              upd,
    input  logic [SADW-1:0]   value,
    input  logic [1:0][CW-1:0] pos,
    output logic [1:0][CW-1:0] best_pos
);
    logic [SADW-1:0] min_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q    <= '1;
            best_pos <= '0;
        end else if (init) begin
            min_q    <= '1;
            best_pos <= init_pos;
        end else if (upd && (value < min_q)) begin
            min_q    <= value;
            best_pos <= pos;
        end
    end
endmodule

// File: rtl/fsbm_search.sv
module fsbm_search #(
    parameter int FRAME = 96,
    parameter int BLK   = 16,
    parameter int RANGE = 16,
    parameter int SADW  = 16,
    parameter int IW    = $clog2(FRAME / BLK),
    parameter int CW    = $clog2(FRAME)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IW-1:0]   mb_col,
    input  logic [IW-1:0]   mb_row,
    output logic            sad_req,
    output logic [CW-1:0]   cand_x,
    output logic [CW-1:0]   cand_y,
    input  logic            sad_done,
    input  logic [SADW-1:0] sad_value,
    output logic            done_req,
    input  logic            done_ack,
    output logic [CW-1:0]   start_x,
    output logic [CW-1:0]   start_y,
    output logic [CW-1:0]   end_x,
    output logic [CW-1:0]   end_y
);
    import fsbm_pkg::*;

    localparam int HALF = BLK / 2;

    fsbm_state_t state, state_nx;
    logic               issued;
    logic [1:0][IW-1:0] idx_q;
    logic [1:0][IW-1:0] idx_now;
    logic [1:0][CW-1:0] org, lo, top, pos, best;
    logic               last;
    logic               accept;
    logic               result;

    assign accept = (state == ST_RESET) && start;
    assign result = (state == ST_CALC) && issued && sad_done;

    always_comb begin
        if (state == ST_RESET) begin
            idx_now[0] = mb_col;
            idx_now[1] = mb_row;
        end else begin
            idx_now = idx_q;
        end
    end

    fsbm_window #(
        .FRAME(FRAME), .BLK(BLK), .RANGE(RANGE), .IW(IW), .CW(CW)
    ) u_window (
        .idx (idx_now),
        .org (org),
        .lo  (lo),
        .top (top)
    );

    fsbm_scan #(.CW(CW)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (result && !last),
        .lo    (lo),
        .top   (top),
        .pos   (pos),
        .last  (last)
    );

    fsbm_min_track #(.CW(CW), .SADW(SADW)) u_min (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (accept),
        .init_pos (lo),
        .upd      (result),
        .value    (sad_value),
        .pos      (pos),
        .best_pos (best)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET:    if (start)          state_nx = ST_CALC;
            ST_CALC:     if (result && last) state_nx = ST_DONE;
            ST_DONE:     if (done_ack)       state_nx = ST_COMPLETE;
            ST_COMPLETE:                     state_nx = ST_RESET;
            default:                         state_nx = ST_RESET;
        endcase
    end

    // state register and per-candidate request flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RESET;
            issued <= 1'b0;
            idx_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                idx_q  <= idx_now;
                issued <= 1'b0;
            end else if (state == ST_CALC) begin
                if (!issued) begin
                    issued <= 1'b1;
                end else if (sad_done) begin
                    issued <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sad_req  = (state == ST_CALC) && !issued;
        done_req = (state == ST_DONE);
        cand_x   = pos[0];
        cand_y   = pos[1];
        start_x  = org[0] + CW'(HALF);
        start_y  = org[1] + CW'(HALF);
        end_x    = best[0] + CW'(HALF);
        end_y    = best[1] + CW'(HALF);
    end
endmodule

// File: rtl/fsbm_search_chk.sv
module fsbm_search_chk #(
    parameter int FRAME = 96,
    parameter int BLK   = 16,
    parameter int RANGE = 16,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_calc,
    input logic          sad_req,
    input logic          sad_done,
    input logic          done_req,
    input logic          done_ack,
    input logic [CW-1:0] cand_x,
    input logic [CW-1:0] cand_y,
    input logic [CW-1:0] start_x,
    input logic [CW-1:0] start_y,
    input logic [CW-1:0] end_x,
    input logic [CW-1:0] end_y
);
    localparam int HALF = BLK / 2;

    // R2: candidate inside the clipped window derived from the start point
    p_cand_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sad_req |-> (int'(cand_x) >= int'(start_x) - HALF - RANGE)
                 && (int'(cand_x) <= int'(start_x) - HALF + RANGE)
                 && (int'(cand_x) + BLK <= FRAME)
                 && (int'(cand_y) >= int'(start_y) - HALF - RANGE)
                 && (int'(cand_y) <= int'(start_y) - HALF + RANGE)
                 && (int'(cand_y) + BLK <= FRAME))
        else $error("p_cand_window_r2");

    // R4: request is a single-cycle pulse
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sad_req |=> !sad_req)
        else $error("p_req_pulse_r4");

    // R4: candidate held while its result is outstanding
    p_cand_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_calc && !sad_req) |-> ($stable(cand_x) && $stable(cand_y)))
        else $error("p_cand_stable_r4");

    // R9: no request to the SAD unit while reporting
    p_req_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sad_req && done_req))
        else $error("p_req_done_excl_r9");

    // R9: report held until acknowledged
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_req && !done_ack) |=> done_req)
        else $error("p_done_hold_r9");

    // R9: report drops after acknowledge
    p_done_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_req && done_ack) |=> !done_req)
        else $error("p_done_drop_r9");

    // R10: end point frozen while reporting, stray results ignored
    p_end_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_req && $past(done_req)) |-> ($stable(end_x) && $stable(end_y)))
        else $error("p_end_stable_r10");

    // R7: start point sits at the block-centre offset
    p_start_centre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_req |-> ((int'(start_x) % BLK == HALF) && (int'(start_y) % BLK == HALF)))
        else $error("p_start_centre_r7");
endmodule

bind fsbm_search fsbm_search_chk #(
    .FRAME(FRAME), .BLK(BLK), .RANGE(RANGE), .CW(CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_calc  (state == fsbm_pkg::ST_CALC),
    .sad_req  (sad_req),
    .sad_done (sad_done),
    .done_req (done_req),
    .done_ack (done_ack),
    .cand_x   (cand_x),
    .cand_y   (cand_y),
    .start_x  (start_x),
    .start_y  (start_y),
    .end_x    (end_x),
    .end_y    (end_y)
);

// File: tb/fsbm_search_tb_top.sv
`timescale 1ns/1ps
module fsbm_search_tb_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mb_col = '0;
    logic [2:0]  mb_row = '0;
    logic        sad_req;
    logic [6:0]  cand_x, cand_y;
    logic        sad_done = 1'b0;
    logic [15:0] sad_value = '0;
    logic        done_req;
    logic        done_ack = 1'b0;
    logic [6:0]  start_x, start_y, end_x, end_y;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fsbm_search dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mb_col(mb_col), .mb_row(mb_row),
        .sad_req(sad_req), .cand_x(cand_x), .cand_y(cand_y),
        .sad_done(sad_done), .sad_value(sad_value),
        .done_req(done_req), .done_ack(done_ack),
        .start_x(start_x), .start_y(start_y), .end_x(end_x), .end_y(end_y)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // SAD model: mode 0 distance, 1 row-only (ties), 2 all max, 3 scrambled
    function automatic int sad_model(input int mode, input int x, input int y,
                                     input int tx, input int ty);
        int v;
        case (mode)
            0: v = (iabs(x - tx) + iabs(y - ty)) * 37;
            1: v = iabs(y - ty) * 100;
            2: v = 65535;
            default: v = ((x * 131 + y * 71) ^ (x * y * 7)) % 5000 + 3;
        endcase
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic run_mb(input int col, input int row, input int mode,
                          input int tx, input int ty, input bit poke);
        int ox, oy, lx, ly, mx, my, bx, by, bmin, n;
        ox = col * 16; oy = row * 16;
        lx = (ox - 16 < 0) ? 0 : ox - 16;
        ly = (oy - 16 < 0) ? 0 : oy - 16;
        mx = ((ox + 31 > 95) ? 95 : ox + 31) - 15;
        my = ((oy + 31 > 95) ? 95 : oy + 31) - 15;
        bx = lx; by = ly; bmin = 65535;
        for (int y = ly; y <= my; y++)
            for (int x = lx; x <= mx; x++)
                if (sad_model(mode, x, y, tx, ty) < bmin) begin
                    bmin = sad_model(mode, x, y, tx, ty); bx = x; by = y;
                end

        mb_col = 3'(col); mb_row = 3'(row); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        for (int y = ly; y <= my; y++) begin
            for (int x = lx; x <= mx; x++) begin
                chk(sad_req === 1'b1, "R4 request present", int'(sad_req), 1);
                chk(cand_x == 7'(x), "R2/R3 candidate x", int'(cand_x), x);
                chk(cand_y == 7'(y), "R2/R3 candidate y", int'(cand_y), y);
                for (int k = 0; k < LAT; k++) begin
                    if (poke && n == 2 && k == 0) begin
                        start = 1'b1; mb_col = 3'((col + 3) % 6); mb_row = 3'((row + 2) % 6);
                    end
                    @(negedge clk);
                    start = 1'b0;
                    chk(sad_req === 1'b0 && done_req === 1'b0, "R4 no request while waiting",
                        int'({sad_req, done_req}), 0);
                end
                sad_done = 1'b1;
                sad_value = 16'(sad_model(mode, x, y, tx, ty));
                @(negedge clk);
                sad_done = 1'b0;
                n++;
            end
        end
        chk(done_req === 1'b1, "R9 done after last result", int'(done_req), 1);
        chk(end_x == 7'(bx + 8), "R5/R6/R8 end_x", int'(end_x), bx + 8);
        chk(end_y == 7'(by + 8), "R5/R6/R8 end_y", int'(end_y), by + 8);
        chk(start_x == 7'(ox + 8), "R7 start_x", int'(start_x), ox + 8);
        chk(start_y == 7'(oy + 8), "R7 start_y", int'(start_y), oy + 8);
        // R10: stray result while reporting
        sad_done = 1'b1; sad_value = 16'd0;
        @(negedge clk);
        sad_done = 1'b0;
        @(negedge clk);
        chk(end_x == 7'(bx + 8) && end_y == 7'(by + 8), "R10 stray sad_done ignored",
            int'(end_x), bx + 8);
        chk(done_req === 1'b1, "R9 done held", int'(done_req), 1);
        chk(sad_req === 1'b0, "R10 no request after stray done", int'(sad_req), 0);
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        chk(done_req === 1'b0, "R9 done drops after ack", int'(done_req), 0);
        @(negedge clk);
        chk(sad_req === 1'b0 && done_req === 1'b0, "R9 idle after complete",
            int'({sad_req, done_req}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sad_req === 1'b0, "R1 sad_req in reset", int'(sad_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sad_req === 1'b0 && done_req === 1'b0, "R1 outputs after reset",
            int'({sad_req, done_req}), 0);

        run_mb(0, 0, 0, 20, 30, 1'b0);  // top-left corner
        run_mb(5, 5, 0, 10, 10, 1'b0);  // bottom-right corner, target outside
        run_mb(2, 0, 1, 0, 5, 1'b1);    // top edge, row ties, stray start (R10)
        run_mb(0, 3, 2, 0, 0, 1'b0);    // left edge, all-max SAD (R6)
        run_mb(2, 3, 3, 0, 0, 1'b0);    // interior, scrambled SAD
        run_mb(5, 2, 0, 70, 40, 1'b0);  // right edge
        run_mb(3, 5, 1, 0, 90, 1'b0);   // bottom edge, ties on clipped row

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule